// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counter Unit

This block holds the two error counters of a CAN node, one for transmit errors and one for receive errors, and works out from them whether the node is error-active, error-passive or bus-off. The protocol engine drives it with single-cycle event pulses: a transmit error, a normal receive error, a severe receive error, a successful transmission and a successful reception. It also sends one strobe per sampled bit, which says whether that bit was recessive. The counters move on every event. The node's state is derived from the counter values and from a held bus-off flag.

While the node is bus-off, all frame events are ignored. The receive counter is reused to count completed runs of eleven consecutive recessive bits. The node returns to error-active, with both counters at zero, when the 128th run completes. A configuration-mode level clears both counters. Software always has read access to both counters through a 32-bit register view. Software can write the counters only while a test enable is held, and a write loads the same byte into both of them.

Top module: `can_errcnt_unit`

## Requirements
- R1: A transmit error adds 8 to the transmit counter. A successful transmission subtracts 1 from it, and it stays at 0 when it is already 0.
- R2: A receive error adds 1 and a severe receive error adds 8 to the receive counter. A successful reception subtracts 1 while the counter is between 1 and 127, and leaves 0 unchanged. When an error and a success arrive in the same cycle, the error wins.
- R3: While the receive counter is 128 or more, receive errors and severe receive errors leave it unchanged.
- R4: A successful reception while the receive counter is 128 or more loads it with 119.
- R5: `state_o` reads 0 for error-active, 1 for error-passive and 2 for bus-off. Outside bus-off it is 1 when either counter exceeds 127, and 0 otherwise.
- R6: If a transmit error would take the transmit counter past 255, the node enters bus-off instead. The transmit counter keeps its value and the receive counter is set to 0. In bus-off, every frame event and every success event is ignored.
- R7: In bus-off, each run of 11 consecutive recessive bit strobes adds 1 to the receive counter. A dominant strobe restarts the run, and so does each completed run.
- R8: When the 128th run completes, the node becomes error-active and both counters become 0.
- R9: While configuration mode is high, both counters are cleared to 0 and the node leaves bus-off. This takes priority over every other input.
- R10: A write with the test enable high loads the written byte into both counters. A write with the test enable low has no effect.
- R11: `rd_data_o` carries the receive counter in bits 7:0 and the transmit counter in bits 15:8. Bits 31:16 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode_i | input | 1 | Configuration mode level; clears the counters |
| test_err_en_i | input | 1 | Test enable that allows counter writes |
| ev_tx_err_i | input | 1 | Transmit error pulse |
| ev_rx_err_i | input | 1 | Receive error pulse |
| ev_rx_severe_i | input | 1 | Severe receive error pulse |
| ev_tx_ok_i | input | 1 | Successful transmission pulse |
| ev_rx_ok_i | input | 1 | Successful reception pulse |
| bit_valid_i | input | 1 | Strobe: one sampled bus bit |
| bit_recessive_i | input | 1 | Sampled bit is recessive (valid with strobe) |
| wr_en_i | input | 1 | Counter register write strobe |
| wr_data_i | input | 8 | Written byte (low byte of the register) |
| tec_o | output | 8 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| state_o | output | 2 | Fault-confinement state |
| rd_data_o | output | 32 | Register read view of both counters |

## Verification
The bench builds the block with its default parameters: 8-bit counters, an 11-bit recessive run, a recovery count of 128 runs and a step of 8. With these values the full recovery path, 128 runs of eleven bits or about 1,400 strobes, fits easily in one run. The same values put the 255 overflow edge within a single test write followed by one transmit error. The error-passive cap, the reload to 119 and the floor at 0 are all one event away from a test-mode write, so the vector table reaches each of them directly.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;

    typedef struct packed {
        logic tx_err;
        logic rx_err;
        logic rx_severe;
        logic tx_ok;
        logic rx_ok;
    } err_ev_t;

endpackage

// File: rtl/can_recrun_det.sv
module can_recrun_det #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_valid_i,
    input  logic bit_recessive_i,
    output logic run_done_o
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST_C = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          done_c;

    always_comb begin
        cnt_d  = cnt_q;
        done_c = 1'b0;
        if (!en_i) begin
            cnt_d = '0;
        end else if (bit_valid_i) begin
            if (!bit_recessive_i) begin
                cnt_d = '0;
            end else if (cnt_q == LAST_C) begin
                cnt_d  = '0;
                done_c = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign run_done_o = done_c;

endmodule

// File: rtl/can_err_regif.sv
module can_err_regif #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              test_err_en_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [CNT_W-1:0]  tec_i,
    input  logic [CNT_W-1:0]  rec_i,
    output logic              wr_ok_o,
    output logic [CNT_W-1:0]  wr_val_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int PAD_W = DATA_W - 2 * CNT_W;

    always_comb begin
        wr_ok_o   = wr_en_i & test_err_en_i;
        wr_val_o  = wr_data_i;
        rd_data_o = {{PAD_W{1'b0}}, tec_i, rec_i};
    end

endmodule

// File: rtl/can_err_counters.sv
module can_err_counters
    import can_err_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int TX_STEP      = 8,
    parameter int RX_SEV_STEP  = 8,
    parameter int PASSIVE_LIM  = 128,
    parameter int RELOAD_VAL   = 119,
    parameter int RECOVER_RUNS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode_i,
    input  err_ev_t          ev_i,
    input  logic             wr_ok_i,
    input  logic [CNT_W-1:0] wr_val_i,
    input  logic             run_done_i,
    output logic [CNT_W-1:0] tec_o,
    output logic [CNT_W-1:0] rec_o,
    output logic             busoff_o,
    output fc_state_e        state_o
);
    localparam logic [CNT_W:0]   MAX_W     = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0]   TX_STEP_W = (CNT_W+1)'(TX_STEP);
    localparam logic [CNT_W-1:0] SEV_C     = CNT_W'(RX_SEV_STEP);
    localparam logic [CNT_W-1:0] LIM_C     = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] RELOAD_C  = CNT_W'(RELOAD_VAL);
    localparam logic [CNT_W-1:0] RUNS_LAST = CNT_W'(RECOVER_RUNS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
        logic             busoff;
    } cnt_state_t;

    cnt_state_t     st_d, st_q;
    logic [CNT_W:0] tec_sum;
    logic           enter_busoff;

    always_comb begin
        st_d         = st_q;
        tec_sum      = {1'b0, st_q.tec} + TX_STEP_W;
        enter_busoff = 1'b0;

        if (cfg_mode_i) begin
            st_d.tec    = '0;
            st_d.rec    = '0;
            st_d.busoff = 1'b0;
        end else if (wr_ok_i) begin
            st_d.tec = wr_val_i;
            st_d.rec = wr_val_i;
        end else if (st_q.busoff) begin
            if (run_done_i) begin
                if (st_q.rec == RUNS_LAST) begin
                    st_d.tec    = '0;
                    st_d.rec    = '0;
                    st_d.busoff = 1'b0;
                end else begin
                    st_d.rec = st_q.rec + 1'b1;
                end
            end
        end else begin
            // transmit side
            if (ev_i.tx_err) begin
                if (tec_sum > MAX_W) begin
                    enter_busoff = 1'b1;
                end else begin
                    st_d.tec = tec_sum[CNT_W-1:0];
                end
            end else if (ev_i.tx_ok && (st_q.tec != '0)) begin
                st_d.tec = st_q.tec - 1'b1;
            end

            // receive side
            if (enter_busoff) begin
                st_d.busoff = 1'b1;
                st_d.rec    = '0;
            end else if (ev_i.rx_severe || ev_i.rx_err) begin
                if (st_q.rec < LIM_C) begin
                    st_d.rec = st_q.rec + (ev_i.rx_severe ? SEV_C : CNT_W'(1));
                end
            end else if (ev_i.rx_ok) begin
                if (st_q.rec >= LIM_C) begin
                    st_d.rec = RELOAD_C;
                end else if (st_q.rec != '0) begin
                    st_d.rec = st_q.rec - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        tec_o    = st_q.tec;
        rec_o    = st_q.rec;
        busoff_o = st_q.busoff;
        if (st_q.busoff)
            state_o = FC_BUSOFF;
        else if ((st_q.tec >= LIM_C) || (st_q.rec >= LIM_C))
            state_o = FC_PASSIVE;
        else
            state_o = FC_ACTIVE;
    end

endmodule

// File: rtl/can_errcnt_unit.sv
module can_errcnt_unit
    import can_err_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DATA_W       = 32,
    parameter int RUN_LEN      = 11,
    parameter int TX_STEP      = 8,
    parameter int RX_SEV_STEP  = 8,
    parameter int PASSIVE_LIM  = 128,
    parameter int RELOAD_VAL   = 119,
    parameter int RECOVER_RUNS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mode_i,
    input  logic              test_err_en_i,
    input  logic              ev_tx_err_i,
    input  logic              ev_rx_err_i,
    input  logic              ev_rx_severe_i,
    input  logic              ev_tx_ok_i,
    input  logic              ev_rx_ok_i,
    input  logic              bit_valid_i,
    input  logic              bit_recessive_i,
    input  logic              wr_en_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  tec_o,
    output logic [CNT_W-1:0]  rec_o,
    output logic [1:0]        state_o,
    output logic [DATA_W-1:0] rd_data_o
);
    err_ev_t          ev;
    logic             wr_ok;
    logic [CNT_W-1:0] wr_val;
    logic             run_done;
    logic             busoff;
    fc_state_e        st;

    assign ev = '{tx_err:    ev_tx_err_i,
                  rx_err:    ev_rx_err_i,
                  rx_severe: ev_rx_severe_i,
                  tx_ok:     ev_tx_ok_i,
                  rx_ok:     ev_rx_ok_i};

    can_err_regif #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regif (
        .test_err_en_i (test_err_en_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .tec_i         (tec_o),
        .rec_i         (rec_o),
        .wr_ok_o       (wr_ok),
        .wr_val_o      (wr_val),
        .rd_data_o     (rd_data_o)
    );

    can_recrun_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk             (clk),
        .rst_n           (rst_n),
        .en_i            (busoff & ~cfg_mode_i),
        .bit_valid_i     (bit_valid_i),
        .bit_recessive_i (bit_recessive_i),
        .run_done_o      (run_done)
    );

    can_err_counters #(
        .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_SEV_STEP(RX_SEV_STEP),
        .PASSIVE_LIM(PASSIVE_LIM), .RELOAD_VAL(RELOAD_VAL),
        .RECOVER_RUNS(RECOVER_RUNS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode_i (cfg_mode_i),
        .ev_i       (ev),
        .wr_ok_i    (wr_ok),
        .wr_val_i   (wr_val),
        .run_done_i (run_done),
        .tec_o      (tec_o),
        .rec_o      (rec_o),
        .busoff_o   (busoff),
        .state_o    (st)
    );

    assign state_o = st;

endmodule

// File: rtl/can_err_chk.sv
module can_err_chk #(
    parameter int CNT_W        = 8,
    parameter int DATA_W       = 32,
    parameter int TX_STEP      = 8,
    parameter int PASSIVE_LIM  = 128,
    parameter int RELOAD_VAL   = 119,
    parameter int RECOVER_RUNS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mode_i,
    input logic              test_err_en_i,
    input logic              wr_en_i,
    input logic              ev_tx_err_i,
    input logic              ev_rx_err_i,
    input logic              ev_rx_severe_i,
    input logic              ev_tx_ok_i,
    input logic              ev_rx_ok_i,
    input logic              run_done_i,
    input logic [CNT_W-1:0]  tec_o,
    input logic [CNT_W-1:0]  rec_o,
    input logic [1:0]        state_o,
    input logic [DATA_W-1:0] rd_data_o
);
    localparam logic [CNT_W-1:0] LIM_C    = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD_VAL);
    localparam logic [CNT_W-1:0] TXS_C    = CNT_W'(TX_STEP);
    localparam logic [CNT_W-1:0] TX_EDGE  = CNT_W'((1 << CNT_W) - 1 - TX_STEP);
    localparam logic [CNT_W-1:0] RUNS_L   = CNT_W'(RECOVER_RUNS - 1);

    logic quiet_ctl;
    assign quiet_ctl = !cfg_mode_i && !(wr_en_i && test_err_en_i);

    p_tx_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_ctl && state_o != 2'd2 && ev_tx_err_i && tec_o <= TX_EDGE
        |=> tec_o == $past(tec_o) + TXS_C);

    p_rx_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_ctl && state_o != 2'd2 && !ev_tx_err_i && !ev_rx_ok_i &&
        (ev_rx_err_i || ev_rx_severe_i) && rec_o >= LIM_C
        |=> rec_o == $past(rec_o));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_ctl && state_o != 2'd2 && !ev_tx_err_i && !ev_rx_err_i &&
        !ev_rx_severe_i && ev_rx_ok_i && rec_o >= LIM_C
        |=> rec_o == RELOAD_C);

    p_state_enc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'd3);

    p_busoff_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_ctl && state_o != 2'd2 && ev_tx_err_i && tec_o > TX_EDGE
        |=> state_o == 2'd2 && rec_o == '0 && tec_o == $past(tec_o));

    p_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_ctl && state_o == 2'd2 && run_done_i && rec_o == RUNS_L
        |=> state_o == 2'd0 && tec_o == '0 && rec_o == '0);

    p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode_i |=> tec_o == '0 && rec_o == '0 && state_o == 2'd0);

    p_wr_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && !test_err_en_i && !cfg_mode_i && state_o != 2'd2 &&
        !ev_tx_err_i && !ev_rx_err_i && !ev_rx_severe_i && !ev_tx_ok_i && !ev_rx_ok_i
        |=> $stable(tec_o) && $stable(rec_o));

    p_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:2*CNT_W] == '0);

endmodule

bind can_errcnt_unit can_err_chk #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .TX_STEP(TX_STEP),
    .PASSIVE_LIM(PASSIVE_LIM), .RELOAD_VAL(RELOAD_VAL), .RECOVER_RUNS(RECOVER_RUNS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_mode_i     (cfg_mode_i),
    .test_err_en_i  (test_err_en_i),
    .wr_en_i        (wr_en_i),
    .ev_tx_err_i    (ev_tx_err_i),
    .ev_rx_err_i    (ev_rx_err_i),
    .ev_rx_severe_i (ev_rx_severe_i),
    .ev_tx_ok_i     (ev_tx_ok_i),
    .ev_rx_ok_i     (ev_rx_ok_i),
    .run_done_i     (run_done),
    .tec_o          (tec_o),
    .rec_o          (rec_o),
    .state_o        (state_o),
    .rd_data_o      (rd_data_o)
);

// File: tb/sim_can_errcnt_unit.sv
`timescale 1ns/1ps
module sim_can_errcnt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode_i = 0, test_err_en_i = 0, wr_en_i = 0;
    logic        ev_tx_err_i = 0, ev_rx_err_i = 0, ev_rx_severe_i = 0;
    logic        ev_tx_ok_i = 0, ev_rx_ok_i = 0;
    logic        bit_valid_i = 0, bit_recessive_i = 0;
    logic [7:0]  wr_data_i = 0;
    logic [7:0]  tec_o, rec_o;
    logic [1:0]  state_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    can_errcnt_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .test_err_en_i(test_err_en_i),
        .ev_tx_err_i(ev_tx_err_i), .ev_rx_err_i(ev_rx_err_i), .ev_rx_severe_i(ev_rx_severe_i),
        .ev_tx_ok_i(ev_tx_ok_i), .ev_rx_ok_i(ev_rx_ok_i), .bit_valid_i(bit_valid_i),
        .bit_recessive_i(bit_recessive_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o), .rd_data_o(rd_data_o)
    );

    // ctrl bits: {cfg, test, wr, tx_err, rx_err, rx_sev, tx_ok, rx_ok}
    localparam int NV = 22;
    localparam logic [33:0] VEC [NV] = '{
        {8'b0001_0000, 8'd0,   8'd8,   8'd0,   2'd0}, // R1 tx err +8
        {8'b0000_1000, 8'd0,   8'd8,   8'd1,   2'd0}, // R2 rx err +1
        {8'b0000_0100, 8'd0,   8'd8,   8'd9,   2'd0}, // R2 severe +8
        {8'b0000_0010, 8'd0,   8'd7,   8'd9,   2'd0}, // R1 tx ok -1
        {8'b0000_0001, 8'd0,   8'd7,   8'd8,   2'd0}, // R2 rx ok -1
        {8'b0001_1000, 8'd0,   8'd15,  8'd9,   2'd0}, // R1 R2 together
        {8'b0000_1001, 8'd0,   8'd15,  8'd10,  2'd0}, // R2 error beats ok
        {8'b0010_0000, 8'd80,  8'd15,  8'd10,  2'd0}, // R10 write w/o test ignored
        {8'b0110_0000, 8'd126, 8'd126, 8'd126, 2'd0}, // R10 mirrored write
        {8'b0000_1000, 8'd0,   8'd126, 8'd127, 2'd0}, // R2
        {8'b0000_1000, 8'd0,   8'd126, 8'd128, 2'd1}, // R5 passive
        {8'b0000_1000, 8'd0,   8'd126, 8'd128, 2'd1}, // R3 capped
        {8'b0000_0100, 8'd0,   8'd126, 8'd128, 2'd1}, // R3 severe capped
        {8'b0000_0001, 8'd0,   8'd126, 8'd119, 2'd0}, // R4 reload
        {8'b0001_0000, 8'd0,   8'd134, 8'd119, 2'd1}, // R5 tec passive
        {8'b0000_0010, 8'd0,   8'd133, 8'd119, 2'd1}, // R1
        {8'b0110_0000, 8'd125, 8'd125, 8'd125, 2'd0}, // R10
        {8'b0000_0100, 8'd0,   8'd125, 8'd133, 2'd1}, // R2 severe to 133
        {8'b0000_0001, 8'd0,   8'd125, 8'd119, 2'd0}, // R4 reload from 133
        {8'b1000_0000, 8'd0,   8'd0,   8'd0,   2'd0}, // R9 config clear
        {8'b0000_0010, 8'd0,   8'd0,   8'd0,   2'd0}, // R1 floor
        {8'b0000_0001, 8'd0,   8'd0,   8'd0,   2'd0}  // R2 floor
    };

    task automatic check(input string req, input logic [7:0] et, input logic [7:0] er,
                         input logic [1:0] es);
        checks++;
        if (tec_o !== et || rec_o !== er || state_o !== es ||
            rd_data_o !== {16'd0, et, er}) begin
            errors++;
            $display("FAIL %s: tec=%0d rec=%0d state=%0d rd=%h expected tec=%0d rec=%0d state=%0d rd=%h",
                     req, tec_o, rec_o, state_o, rd_data_o, et, er, es, {16'd0, et, er});
        end
    endtask

    task automatic step(input logic [7:0] c, input logic [7:0] wd);
        {cfg_mode_i, test_err_en_i, wr_en_i, ev_tx_err_i, ev_rx_err_i,
         ev_rx_severe_i, ev_tx_ok_i, ev_rx_ok_i} = c;
        wr_data_i = wd;
        @(negedge clk);
        {cfg_mode_i, test_err_en_i, wr_en_i, ev_tx_err_i, ev_rx_err_i,
         ev_rx_severe_i, ev_tx_ok_i, ev_rx_ok_i} = 8'd0;
        wr_data_i = 8'd0;
    endtask

    task automatic send_bit(input logic r);
        bit_valid_i = 1'b1;
        bit_recessive_i = r;
        @(negedge clk);
        bit_valid_i = 1'b0;
        bit_recessive_i = 1'b0;
    endtask

    task automatic send_run();
        for (int k = 0; k < 11; k++) send_bit(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset", 8'd0, 8'd0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][33:26], VEC[i][25:18]);
            check($sformatf("vector %0d (R1-R5,R9-R11 table)", i),
                  VEC[i][17:10], VEC[i][9:2], VEC[i][1:0]);
        end

        // R6: overflow of the transmit counter enters bus-off
        step(8'b0110_0000, 8'd250);
        check("R10 write 250", 8'd250, 8'd250, 2'd1);
        step(8'b0001_0000, 8'd0);
        check("R6 bus-off entry", 8'd250, 8'd0, 2'd2);
        step(8'b0001_1111, 8'd0);
        check("R6 events ignored in bus-off", 8'd250, 8'd0, 2'd2);

        // R7: dominant bit restarts the run
        for (int k = 0; k < 10; k++) send_bit(1'b1);
        send_bit(1'b0);
        check("R7 dominant restart", 8'd250, 8'd0, 2'd2);
        send_run();
        check("R7 first run", 8'd250, 8'd1, 2'd2);
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        send_bit(1'b0);
        for (int k = 0; k < 126; k++) send_run();
        check("R7 127 runs", 8'd250, 8'd127, 2'd2);
        send_run();
        check("R8 recovery", 8'd0, 8'd0, 2'd0);

        // recessive bits outside bus-off do nothing
        send_run();
        check("R7 no count outside bus-off", 8'd0, 8'd0, 2'd0);

        // R9: config mode clears out of bus-off
        step(8'b0110_0000, 8'd252);
        step(8'b0001_0000, 8'd0);
        check("R6 second entry", 8'd252, 8'd0, 2'd2);
        send_run();
        check("R7 run counted", 8'd252, 8'd1, 2'd2);
        step(8'b1000_0000, 8'd0);
        check("R9 clear in bus-off", 8'd0, 8'd0, 2'd0);

        // R10 write with test enable but no strobe
        step(8'b0100_0000, 8'd77);
        check("R10 no strobe ignored", 8'd0, 8'd0, 2'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule